// File: doc/BRIEF.md
# Packet Statistics Adaptation Engine

This block counts packets per classification rule over a fixed measurement window and, when the window ends, names the counter row with the most traffic. That row is the candidate for the next slot reconfiguration. A reconfiguration controller outside the block consumes the result. Each packet arrives with a rule key that an upstream header parser has already extracted. The key selects an entry in a direct-mapped rule table. A valid entry points at one counter row, and that row is incremented. Pure TCP acknowledgements are not counted.

Rules are installed and withdrawn through a management command queue. Counter rows are handed out from a free-row queue and returned to it on removal. After reset, an initialisation walk fills the free-row queue in ascending order and clears every counter. Each window then runs through four phases: counting, a short pipeline drain, a scan that reads and clears every row one per cycle, and a single report cycle.

Top module: `pkt_stat_adapt`

## Requirements
- R1: During reset and the ROWS-cycle initialisation walk after it, cand_valid_o and cmd_done_o stay low and no queued command is executed; cmd_ready_o is high while reset is applied.
- R2: An add command (cmd_remove_i=0) for an unmapped rule takes the head of the free-row queue; after reset rows are handed out in ascending order 0,1,2,...
- R3: An add command while no free row remains completes with cmd_err_o=1 together with cmd_done_o and changes no table.
- R4: An add for a rule that is already mapped, or a remove (cmd_remove_i=1) for a rule that is not mapped, completes with cmd_err_o=1.
- R5: A remove frees the rule's row to the tail of the free-row queue, where a later add takes it; packets for the removed rule are no longer counted.
- R6: A counted packet whose rule is mapped adds one to that rule's row; packets for unmapped rules change no row.
- R7: A packet with protocol 6, flags exactly 8'h10 and an empty payload is not counted; any other combination counts.
- R8: Counting lasts INTERVAL cycles. It is followed by 2 drain cycles, ROWS scan cycles and a one-cycle cand_valid_o pulse, so pulses are INTERVAL+ROWS+3 cycles apart. Packets presented outside the counting phase are not counted.
- R9: The report gives the row with the highest count together with that count. Ties go to the lowest row index.
- R10: The scan clears every counter, so each window starts from zero.
- R11: A counter holds at 2^CNT_W-1 rather than wrapping.
- R12: Commands wait in a CMD_DEPTH-entry queue, and cmd_ready_o is low while that queue is full. At most one command executes per cycle, and only in the counting phase. cmd_done_o (with cmd_err_o) pulses one cycle after the command executes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pkt_valid_i | input | 1 | Packet header present this cycle |
| pkt_rule_i | input | RULE_AW | Rule key extracted from the header |
| pkt_proto_i | input | 8 | IP protocol number |
| pkt_flags_i | input | 8 | TCP flag byte |
| pkt_empty_i | input | 1 | Payload length is zero |
| cmd_valid_i | input | 1 | Management command offered |
| cmd_ready_o | output | 1 | Command queue has room |
| cmd_remove_i | input | 1 | 0 = add rule, 1 = remove rule |
| cmd_rule_i | input | RULE_AW | Rule key the command targets |
| cmd_done_o | output | 1 | A command finished (one-cycle pulse) |
| cmd_err_o | output | 1 | The finished command was rejected |
| cand_valid_o | output | 1 | Candidate report pulse |
| cand_row_o | output | ROW_AW | Most active counter row |
| cand_count_o | output | CNT_W | Count of that row |

## Verification
The bench builds the engine with 16 rules, 4 counter rows, 4-bit counters, a 100-cycle window and a 2-entry command queue. With four rows, the free-row queue runs dry after four adds, so rejected adds and row recycling can be reached in a single window. With 4-bit counters, saturation at 15 is reached with a few dozen packets. The 2-entry queue fills during the short initialisation walk, which makes backpressure observable. Two saturated rows force the tie rule to decide the report.

// File: rtl/paf_pkg.sv
package paf_pkg;
  typedef enum logic [2:0] {
    PH_INIT, PH_COUNT, PH_DRAIN, PH_SCAN, PH_REPORT
  } phase_e;

  localparam logic [7:0] PROTO_TCP      = 8'd6;
  localparam logic [7:0] FLAGS_ACK_ONLY = 8'h10;
endpackage

// File: rtl/paf_fifo.sv
module paf_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] data_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [AW:0]   FULL = (AW+1)'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rd_q, wr_q;
  logic [AW:0]   cnt_q;
  logic          push_ok, pop_ok;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == FULL);
  assign push_ok = push_i && !full_o;
  assign pop_ok  = pop_i && !empty_o;
  assign data_o  = mem[rd_q];

  always_ff @(posedge clk_i) begin
    if (push_ok) mem[wr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_ok) wr_q <= (wr_q == LAST) ? '0 : wr_q + 1'b1;
      if (pop_ok)  rd_q <= (rd_q == LAST) ? '0 : rd_q + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/paf_max.sv
module paf_max #(
  parameter int IW = 9,
  parameter int VW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          first_i,
  input  logic          valid_i,
  input  logic [IW-1:0] idx_i,
  input  logic [VW-1:0] val_i,
  output logic [IW-1:0] best_idx_o,
  output logic [VW-1:0] best_val_o
);
  // strict compare keeps the earlier (lower) index on a tie
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      best_idx_o <= '0;
      best_val_o <= '0;
    end else if (valid_i && (first_i || val_i > best_val_o)) begin
      best_idx_o <= idx_i;
      best_val_o <= val_i;
    end
  end
endmodule

// File: rtl/pkt_stat_adapt.sv
module pkt_stat_adapt
  import paf_pkg::*;
#(
  parameter int RULES     = 1024,
  parameter int ROWS      = 512,
  parameter int CNT_W     = 16,
  parameter int INTERVAL  = 100000,
  parameter int CMD_DEPTH = 8,
  localparam int RULE_AW  = $clog2(RULES),
  localparam int ROW_AW   = $clog2(ROWS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               pkt_valid_i,
  input  logic [RULE_AW-1:0] pkt_rule_i,
  input  logic [7:0]         pkt_proto_i,
  input  logic [7:0]         pkt_flags_i,
  input  logic               pkt_empty_i,
  input  logic               cmd_valid_i,
  output logic               cmd_ready_o,
  input  logic               cmd_remove_i,
  input  logic [RULE_AW-1:0] cmd_rule_i,
  output logic               cmd_done_o,
  output logic               cmd_err_o,
  output logic               cand_valid_o,
  output logic [ROW_AW-1:0]  cand_row_o,
  output logic [CNT_W-1:0]   cand_count_o
);
  localparam int TMR_W = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
  localparam logic [TMR_W-1:0]  TMR_LAST = TMR_W'(INTERVAL - 1);
  localparam logic [ROW_AW-1:0] ROW_LAST = ROW_AW'(ROWS - 1);
  localparam logic [CNT_W-1:0]  CNT_MAX  = '1;

  phase_e             phase_q;
  logic [TMR_W-1:0]   timer_q;
  logic [ROW_AW-1:0]  idx_q;
  logic               drain_q;

  // rule table
  logic [RULES-1:0]   rule_vld_q;
  logic [ROW_AW-1:0]  rule_row [RULES];
  logic [CNT_W-1:0]   cnt_mem  [ROWS];

  // command path
  logic               cmd_full, cmd_empty;
  logic [RULE_AW:0]   cmd_head;
  logic               head_del, head_hit;
  logic [RULE_AW-1:0] head_rule;
  logic               cmd_go, add_ok, del_ok, cmd_bad;

  assign cmd_ready_o = !cmd_full;

  paf_fifo #(.W(RULE_AW + 1), .DEPTH(CMD_DEPTH)) u_cmd_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (cmd_valid_i),
    .data_i  ({cmd_remove_i, cmd_rule_i}),
    .pop_i   (cmd_go),
    .data_o  (cmd_head),
    .empty_o (cmd_empty),
    .full_o  (cmd_full)
  );

  assign head_del  = cmd_head[RULE_AW];
  assign head_rule = cmd_head[RULE_AW-1:0];
  assign head_hit  = rule_vld_q[head_rule];

  // free-row queue
  logic               free_push, free_empty, free_full;
  logic [ROW_AW-1:0]  free_in, free_row;

  assign cmd_go  = (phase_q == PH_COUNT) && !cmd_empty;
  assign add_ok  = cmd_go && !head_del && !head_hit && !free_empty;
  assign del_ok  = cmd_go && head_del && head_hit;
  assign cmd_bad = cmd_go && !add_ok && !del_ok;

  assign free_push = (phase_q == PH_INIT) || del_ok;
  assign free_in   = (phase_q == PH_INIT) ? idx_q : rule_row[head_rule];

  paf_fifo #(.W(ROW_AW), .DEPTH(ROWS)) u_free_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (free_push),
    .data_i  (free_in),
    .pop_i   (add_ok),
    .data_o  (free_row),
    .empty_o (free_empty),
    .full_o  (free_full)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rule_vld_q <= '0;
      cmd_done_o <= 1'b0;
      cmd_err_o  <= 1'b0;
    end else begin
      if (add_ok) rule_vld_q[head_rule] <= 1'b1;
      if (del_ok) rule_vld_q[head_rule] <= 1'b0;
      cmd_done_o <= cmd_go;
      cmd_err_o  <= cmd_bad;
    end
  end

  always_ff @(posedge clk_i) begin
    if (add_ok) rule_row[head_rule] <= free_row;
  end

  // packet pipeline: accept -> lookup -> count
  logic               pure_ack, take;
  logic               s1_vld_q, s2_vld_q;
  logic [RULE_AW-1:0] s1_rule_q;
  logic [ROW_AW-1:0]  s2_row_q;
  logic [CNT_W-1:0]   cur_cnt, inc_cnt, scan_cnt;

  assign pure_ack = (pkt_proto_i == PROTO_TCP) && (pkt_flags_i == FLAGS_ACK_ONLY) && pkt_empty_i;
  assign take     = pkt_valid_i && (phase_q == PH_COUNT) && !pure_ack;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_vld_q  <= 1'b0;
      s1_rule_q <= '0;
      s2_vld_q  <= 1'b0;
      s2_row_q  <= '0;
    end else begin
      s1_vld_q  <= take;
      s1_rule_q <= pkt_rule_i;
      s2_vld_q  <= s1_vld_q && rule_vld_q[s1_rule_q];
      s2_row_q  <= rule_row[s1_rule_q];
    end
  end

  assign cur_cnt  = cnt_mem[s2_row_q];
  assign inc_cnt  = (cur_cnt == CNT_MAX) ? cur_cnt : cur_cnt + 1'b1;
  assign scan_cnt = cnt_mem[idx_q];

  // clears are written last so they win over a stale increment
  always_ff @(posedge clk_i) begin
    if (s2_vld_q) cnt_mem[s2_row_q] <= inc_cnt;
    if (phase_q == PH_INIT || phase_q == PH_SCAN) cnt_mem[idx_q] <= '0;
    if (add_ok) cnt_mem[free_row] <= '0;
  end

  // phase sequencer
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_INIT;
      timer_q <= '0;
      idx_q   <= '0;
      drain_q <= 1'b0;
    end else begin
      unique case (phase_q)
        PH_INIT: begin
          idx_q <= idx_q + 1'b1;
          if (idx_q == ROW_LAST) begin
            phase_q <= PH_COUNT;
            idx_q   <= '0;
            timer_q <= '0;
          end
        end
        PH_COUNT: begin
          timer_q <= timer_q + 1'b1;
          if (timer_q == TMR_LAST) begin
            phase_q <= PH_DRAIN;
            drain_q <= 1'b0;
          end
        end
        PH_DRAIN: begin
          drain_q <= 1'b1;
          if (drain_q) begin
            phase_q <= PH_SCAN;
            idx_q   <= '0;
          end
        end
        PH_SCAN: begin
          idx_q <= idx_q + 1'b1;
          if (idx_q == ROW_LAST) begin
            phase_q <= PH_REPORT;
            idx_q   <= '0;
          end
        end
        PH_REPORT: begin
          phase_q <= PH_COUNT;
          timer_q <= '0;
        end
        default: phase_q <= PH_INIT;
      endcase
    end
  end

  paf_max #(.IW(ROW_AW), .VW(CNT_W)) u_max (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .first_i    (idx_q == '0),
    .valid_i    (phase_q == PH_SCAN),
    .idx_i      (idx_q),
    .val_i      (scan_cnt),
    .best_idx_o (cand_row_o),
    .best_val_o (cand_count_o)
  );

  assign cand_valid_o = (phase_q == PH_REPORT);
endmodule

// File: rtl/paf_chk.sv
module paf_chk
  import paf_pkg::*;
(
  input logic   clk_i,
  input logic   rst_ni,
  input logic   cand_valid_i,
  input logic   cmd_done_i,
  input logic   cmd_err_i,
  input phase_e phase_i,
  input logic   free_push_i,
  input logic   free_full_i,
  input logic   s2_vld_i
);
  assert_single_report_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cand_valid_i |=> !cand_valid_i);

  assert_err_with_done_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_err_i |-> cmd_done_i);

  assert_cmd_in_count_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_done_i |-> $past(phase_i == PH_COUNT));

  assert_free_no_overflow_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(free_push_i && free_full_i));

  assert_count_in_window_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s2_vld_i |-> (phase_i == PH_COUNT || phase_i == PH_DRAIN));
endmodule

bind pkt_stat_adapt paf_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cand_valid_i (cand_valid_o),
  .cmd_done_i   (cmd_done_o),
  .cmd_err_i    (cmd_err_o),
  .phase_i      (phase_q),
  .free_push_i  (free_push),
  .free_full_i  (free_full),
  .s2_vld_i     (s2_vld_q)
);

// File: tb/sim_pkt_stat_adapt.sv
`timescale 1ns/1ps
module sim_pkt_stat_adapt;
  localparam int RULES = 16, ROWS = 4, CNT_W = 4, INTERVAL = 100, CMD_DEPTH = 2;
  localparam int SPACING = INTERVAL + ROWS + 3;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n;
  logic       pkt_valid, pkt_empty, cmd_valid, cmd_remove;
  logic [3:0] pkt_rule, cmd_rule;
  logic [7:0] pkt_proto, pkt_flags;
  logic       cmd_ready, cmd_done, cmd_err, cand_valid;
  logic [1:0] cand_row;
  logic [3:0] cand_count;

  pkt_stat_adapt #(.RULES(RULES), .ROWS(ROWS), .CNT_W(CNT_W),
                   .INTERVAL(INTERVAL), .CMD_DEPTH(CMD_DEPTH)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .pkt_valid_i(pkt_valid), .pkt_rule_i(pkt_rule), .pkt_proto_i(pkt_proto),
    .pkt_flags_i(pkt_flags), .pkt_empty_i(pkt_empty),
    .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready), .cmd_remove_i(cmd_remove),
    .cmd_rule_i(cmd_rule), .cmd_done_o(cmd_done), .cmd_err_o(cmd_err),
    .cand_valid_o(cand_valid), .cand_row_o(cand_row), .cand_count_o(cand_count)
  );

  int n_chk = 0, n_bad = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic send_cmd(input bit del, input int rule);
    cmd_remove = del;
    cmd_rule   = 4'(rule);
    cmd_valid  = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_done(input bit exp_err, input string tag);
    int t = 0;
    do begin
      @(negedge clk);
      t++;
    end while (!cmd_done && t < 50);
    chk(cmd_done && (cmd_err == exp_err), tag, int'(cmd_err), int'(exp_err));
  endtask

  task automatic do_cmd(input bit del, input int rule, input bit exp_err, input string tag);
    send_cmd(del, rule);
    wait_done(exp_err, tag);
  endtask

  task automatic send_pkt(input int rule, input int proto, input int flags, input bit empty);
    pkt_rule  = 4'(rule);
    pkt_proto = 8'(proto);
    pkt_flags = 8'(flags);
    pkt_empty = empty;
    pkt_valid = 1'b1;
    @(negedge clk);
    pkt_valid = 1'b0;
  endtask

  task automatic send_n(input int rule, input int n);
    for (int i = 0; i < n; i++) send_pkt(rule, 17, 0, 1'b0);
  endtask

  task automatic wait_cand(output int row, output int cnt, output int at);
    do @(negedge clk); while (!cand_valid);
    row = int'(cand_row);
    cnt = int'(cand_count);
    at  = cyc;
  endtask

  task automatic t_reset_and_queue();
    rst_n = 1'b0;
    pkt_valid = 0; pkt_rule = 0; pkt_proto = 0; pkt_flags = 0; pkt_empty = 0;
    cmd_valid = 0; cmd_remove = 0; cmd_rule = 0;
    repeat (3) @(negedge clk);
    chk(!cand_valid && !cmd_done, "R1 outputs idle in reset", int'(cand_valid), 0);
    chk(cmd_ready, "R1 ready in reset", int'(cmd_ready), 1);
    rst_n = 1'b1;
    cmd_valid = 1'b1; cmd_remove = 1'b1; cmd_rule = 4'd1;
    @(negedge clk);
    cmd_rule = 4'd2;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(!cmd_ready, "R12 queue full backpressure", int'(cmd_ready), 0);
    chk(!cmd_done, "R1 no command during init", int'(cmd_done), 0);
    wait_done(1'b1, "R4 remove unmapped (queued 1)");
    wait_done(1'b1, "R4 remove unmapped (queued 2)");
  endtask

  int r, c, a_prev, a_now;

  task automatic t_mixed_traffic();
    do_cmd(0, 3, 0, "R2 add rule 3");
    do_cmd(0, 7, 0, "R2 add rule 7");
    do_cmd(0, 9, 0, "R2 add rule 9");
    do_cmd(0, 11, 0, "R2 add rule 11");
    do_cmd(0, 5, 1, "R3 add with no free row");
    do_cmd(0, 3, 1, "R4 add of mapped rule");
    do_cmd(1, 12, 1, "R4 remove of unmapped rule");
    send_n(3, 2);
    for (int i = 0; i < 4; i++) send_pkt(7, 6, 8'h10, 1'b1);  // R7 pure ack
    send_pkt(3, 6, 8'h10, 1'b0);                               // R7 ack with payload
    send_n(7, 3);
    send_n(9, 5);
    send_n(11, 5);
    send_n(12, 6);                                             // R6 unmapped
    wait_cand(r, c, a_now);
    chk(a_now - a_prev == SPACING, "R8 report spacing", a_now - a_prev, SPACING);
    chk(r == 2, "R9 R2 R6 R7 candidate row", r, 2);
    chk(c == 5, "R6 R7 candidate count", c, 5);
    a_prev = a_now;
    send_pkt(9, 17, 0, 1'b0);  // R8 presented in report cycle
  endtask

  task automatic t_cleared_window();
    wait_cand(r, c, a_now);
    chk(a_now - a_prev == SPACING, "R8 report spacing 2", a_now - a_prev, SPACING);
    chk(r == 0 && c == 0, "R10 R8 counters cleared, late packet dropped", c, 0);
    a_prev = a_now;
  endtask

  task automatic t_recycle_saturate();
    do_cmd(1, 7, 0, "R5 remove rule 7");
    do_cmd(0, 13, 0, "R5 add takes recycled row");
    do_cmd(0, 14, 1, "R3 free rows exhausted again");
    send_n(7, 3);
    send_n(9, 20);
    send_n(13, 16);
    wait_cand(r, c, a_now);
    chk(r == 1, "R9 R5 tie to lower row", r, 1);
    chk(c == 15, "R11 saturated count", c, 15);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R8 watchdog expired actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset_and_queue();
    wait_cand(r, c, a_prev);
    chk(r == 0 && c == 0, "R9 all-zero tie reports row 0", r, 0);
    t_mixed_traffic();
    t_cleared_window();
    t_recycle_saturate();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule